// File: doc/BRIEF.md
# Graded Per-Queue Backpressure Controller

This block sits on the receive side of a switching element. The element keeps one queue for each pairing of a sending port and a service class. The block watches the fill level of every one of these queues and decides when each sender must be slowed down. Each backpressure message names one queue, given as its sending port and its class. The sender can then throttle only that flow.

Each queue's fill level is compared with three thresholds: low, middle and stop.

- Below the low threshold the queue stays silent.
- Between the low and middle thresholds a message goes out once every eight slots.
- Between the middle and stop thresholds a message goes out once every two slots.
- At or above the stop threshold the queue latches a stop condition. It then emits a stop-flagged message every slot until its fill drops below the low threshold again.

At most one message leaves per slot. Requesting queues are served in round-robin order. Thresholds are written per queue. A per-queue error flag marks any setting that leaves too little room for cells still arriving during a link round trip.

Top module: `bp_flow_ctrl`

## Requirements
- R1: After reset, no message is issued, `stop_vec` and `cfg_err` are all zero, and every queue uses the default thresholds: low 8, middle 16, stop 24 with default parameters.
- R2: Queue index q equals src*N_CLS+cls. Its fill level is `occ[q*OW +: OW]`. A message for queue q drives `bp_src`=q/N_CLS and `bp_cls`=q%N_CLS. Each message appears one cycle after the request is registered.
- R3: A queue whose fill is below its low threshold, and which holds no stop, issues no message.
- R4: A queue with low <= fill < middle issues exactly one message per 8 slots, with `bp_stop` low.
- R5: A queue with middle <= fill < stop issues exactly one message per 2 slots, with `bp_stop` low.
- R6: A fill at or above the stop threshold sets `stop_vec[q]` on the next cycle. While that bit is set, the queue requests every slot and its messages carry `bp_stop` high.
- R7: Once set, `stop_vec[q]` stays set while fill is at or above the low threshold. It clears only after fill goes below low.
- R8: At most one message is issued per slot. Requesting queues are granted in rotating order starting after the last one served.
- R9: A cycle with `cfg_we` high loads `cfg_lo`, `cfg_mid` and `cfg_stop` into queue `cfg_qid`. The new values take effect from the next cycle.
- R10: `cfg_err[q]` is high when queue q's stop threshold exceeds DEPTH-2*RTT, or when low > middle, or when middle > stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| occ | input | NQ*OW | Fill level of every queue, queue q at bits q*OW upward |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_qid | input | QW | Queue addressed by the write |
| cfg_lo | input | OW | Low threshold to write |
| cfg_mid | input | OW | Middle threshold to write |
| cfg_stop | input | OW | Stop threshold to write |
| stop_vec | output | NQ | Latched stop state per queue |
| cfg_err | output | NQ | Threshold setting violates headroom or ordering |
| bp_valid | output | 1 | A message is issued this slot |
| bp_src | output | SW | Sending port the message targets |
| bp_cls | output | CW | Class the message targets |
| bp_stop | output | 1 | Message is a stop rather than a slow-down |

## Verification
The bench uses the defaults: two senders, two classes, depth 32 and a round trip of 4 cells. This gives four queues and a headroom limit of 24. With so few queues, every fill level from 0 to 32 can be swept on every queue, and the message count in a 64-slot window can be compared with the count expected for the band. A second sweep runs with reprogrammed thresholds. Four queues are also few enough to check the rotation order message by message when all of them are stopped. A mixed case checks that a stopped queue does not starve a slow-band queue.

// File: rtl/bp_flow_ctrl.sv
module bp_flow_ctrl #(
  parameter int N_IN     = 2,
  parameter int N_CLS    = 2,
  parameter int DEPTH    = 32,
  parameter int RTT      = 4,
  parameter int DEF_LO   = 8,
  parameter int DEF_MID  = 16,
  parameter int DEF_STOP = 24,
  localparam int NQ = N_IN * N_CLS,
  localparam int OW = $clog2(DEPTH + 1),
  localparam int QW = $clog2(NQ),
  localparam int SW = $clog2(N_IN),
  localparam int CW = $clog2(N_CLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NQ*OW-1:0]  occ,
  input  logic              cfg_we,
  input  logic [QW-1:0]     cfg_qid,
  input  logic [OW-1:0]     cfg_lo,
  input  logic [OW-1:0]     cfg_mid,
  input  logic [OW-1:0]     cfg_stop,
  output logic [NQ-1:0]     stop_vec,
  output logic [NQ-1:0]     cfg_err,
  output logic              bp_valid,
  output logic [SW-1:0]     bp_src,
  output logic [CW-1:0]     bp_cls,
  output logic              bp_stop
);
  localparam int LIMIT = DEPTH - 2 * RTT;

  logic [NQ-1:0][OW-1:0] occ_q, lo_th, mid_th, stop_th;
  logic [NQ-1:0] stop_r, pend, req, gnt;
  logic [2:0]    slot;
  logic [QW-1:0] ptr, gidx;
  logic          found;

  assign occ_q    = occ;
  assign stop_vec = stop_r;
  assign req      = stop_r | pend;

  always_ff @(posedge clk) begin
    if (!rst_n) slot <= '0;
    else        slot <= slot + 3'd1;
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic lo_hit, mid_hit, stop_hit, tick;
    assign lo_hit   = occ_q[q] >= lo_th[q];
    assign mid_hit  = occ_q[q] >= mid_th[q];
    assign stop_hit = occ_q[q] >= stop_th[q];
    assign tick     = mid_hit ? slot[0] : (lo_hit && slot == 3'd7);
    assign cfg_err[q] = (32'(stop_th[q]) > LIMIT) || (lo_th[q] > mid_th[q])
                        || (mid_th[q] > stop_th[q]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_th[q]   <= OW'(DEF_LO);
        mid_th[q]  <= OW'(DEF_MID);
        stop_th[q] <= OW'(DEF_STOP);
        stop_r[q]  <= 1'b0;
        pend[q]    <= 1'b0;
      end else begin
        if (cfg_we && cfg_qid == QW'(q)) begin
          lo_th[q]   <= cfg_lo;
          mid_th[q]  <= cfg_mid;
          stop_th[q] <= cfg_stop;
        end
        if (stop_hit)    stop_r[q] <= 1'b1;
        else if (!lo_hit) stop_r[q] <= 1'b0;
        if (!lo_hit) pend[q] <= 1'b0;
        else         pend[q] <= (pend[q] & ~gnt[q]) | tick;
      end
    end
  end

  always_comb begin
    int idx;
    found = 1'b0;
    gidx  = ptr;
    for (int i = 0; i < NQ; i++) begin
      idx = (int'(ptr) + i) % NQ;
      if (!found && req[idx]) begin
        found = 1'b1;
        gidx  = QW'(idx);
      end
    end
    gnt = found ? (NQ'(1) << gidx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      bp_valid <= 1'b0;
      bp_src   <= '0;
      bp_cls   <= '0;
      bp_stop  <= 1'b0;
    end else begin
      if (found) ptr <= (int'(gidx) == NQ - 1) ? '0 : gidx + 1'b1;
      bp_valid <= found;
      bp_src   <= SW'(int'(gidx) / N_CLS);
      bp_cls   <= CW'(int'(gidx) % N_CLS);
      bp_stop  <= found && stop_r[gidx];
    end
  end
endmodule

// File: rtl/bp_flow_ctrl_chk.sv
module bp_flow_ctrl_chk #(
  parameter int NQ = 4,
  parameter int OW = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NQ-1:0][OW-1:0] occ_q,
  input logic [NQ-1:0][OW-1:0] lo_th,
  input logic [NQ-1:0][OW-1:0] stop_th,
  input logic [NQ-1:0]         stop_vec,
  input logic                  bp_valid,
  input logic                  bp_stop
);
  a_r6_stop_every_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (|stop_vec) |=> bp_valid);

  a_r8_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    bp_stop |-> bp_valid);

  for (genvar q = 0; q < NQ; q++) begin : g_chk
    a_r7_release_below_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_vec[q]) |-> ($past(occ_q[q]) < $past(lo_th[q])));

    a_r6_entry_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_vec[q]) |-> ($past(occ_q[q]) >= $past(stop_th[q])));
  end
endmodule

bind bp_flow_ctrl bp_flow_ctrl_chk #(.NQ(NQ), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .occ_q(occ_q), .lo_th(lo_th), .stop_th(stop_th),
  .stop_vec(stop_vec), .bp_valid(bp_valid), .bp_stop(bp_stop)
);

// File: tb/bp_flow_ctrl_tb.sv
module bp_flow_ctrl_tb;
  localparam int NQ = 4, OW = 6;

  logic clk = 0, rst_n = 0;
  logic [NQ*OW-1:0] occ = '0;
  logic cfg_we = 0;
  logic [1:0] cfg_qid = '0;
  logic [OW-1:0] cfg_lo = '0, cfg_mid = '0, cfg_stop = '0;
  logic [NQ-1:0] stop_vec, cfg_err;
  logic bp_valid, bp_stop;
  logic [0:0] bp_src, bp_cls;

  int errors = 0, checks = 0;
  int cnt[NQ], scnt[NQ];
  bit rot_chk = 0, done = 0;

  always #5 clk = ~clk;

  bp_flow_ctrl u_dut (.clk(clk), .rst_n(rst_n), .occ(occ), .cfg_we(cfg_we),
    .cfg_qid(cfg_qid), .cfg_lo(cfg_lo), .cfg_mid(cfg_mid), .cfg_stop(cfg_stop),
    .stop_vec(stop_vec), .cfg_err(cfg_err), .bp_valid(bp_valid),
    .bp_src(bp_src), .bp_cls(bp_cls), .bp_stop(bp_stop));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_occ(int q, int v);
    occ[q*OW +: OW] = OW'(v);
  endtask

  task automatic clear_all();
    @(negedge clk);
    occ = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(int q, int lo, int mid, int st);
    @(negedge clk);
    cfg_we = 1; cfg_qid = 2'(q);
    cfg_lo = OW'(lo); cfg_mid = OW'(mid); cfg_stop = OW'(st);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic window(int n);
    int prev = -1;
    for (int i = 0; i < NQ; i++) begin cnt[i] = 0; scnt[i] = 0; end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (bp_valid) begin
        int q = int'(bp_src) * 2 + int'(bp_cls);
        cnt[q]++;
        if (bp_stop) scnt[q]++;
        if (rot_chk && prev >= 0) check("R8 rotation", q, (prev + 1) % NQ);
        prev = q;
      end
    end
  endtask

  function automatic int exp_cnt(int v, int lo, int mid, int st);
    if (v >= st) return 64;
    if (v >= mid) return 32;
    if (v >= lo) return 8;
    return 0;
  endfunction

  task automatic sweep(int q, int lo, int mid, int st, int vmax);
    for (int v = 0; v <= vmax; v++) begin
      clear_all();
      set_occ(q, v);
      repeat (16) @(negedge clk);
      window(64);
      check("R3/R4/R5/R6 count", cnt[q], exp_cnt(v, lo, mid, st));
      check("R6 stop flag count", scnt[q], (v >= st) ? 64 : 0);
      check("R6 stop_vec", int'(stop_vec[q]), int'(v >= st));
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 bp_valid", int'(bp_valid), 0);
    check("R1 stop_vec", int'(stop_vec), 0);
    check("R1 cfg_err", int'(cfg_err), 0);

    // R2 R3 R4 R5 R6: full sweep with default thresholds on every queue
    for (int q = 0; q < NQ; q++) sweep(q, 8, 16, 24, 32);

    // R9: reprogram queue 2, sweep again
    cfg(2, 4, 6, 10);
    check("R9 cfg_err legal", int'(cfg_err), 0);
    sweep(2, 4, 6, 10, 16);
    cfg(2, 8, 16, 24);

    // R10 headroom and ordering
    cfg(1, 8, 16, 25);
    check("R10 stop over limit", int'(cfg_err[1]), 1);
    cfg(1, 8, 16, 24);
    check("R10 stop at limit", int'(cfg_err[1]), 0);
    cfg(1, 17, 16, 24);
    check("R10 low above mid", int'(cfg_err[1]), 1);
    cfg(1, 8, 20, 18);
    check("R10 mid above stop", int'(cfg_err[1]), 1);
    cfg(1, 8, 16, 24);
    check("R10 restored", int'(cfg_err), 0);

    // R7 hysteresis
    clear_all();
    set_occ(0, 24);
    repeat (4) @(negedge clk);
    check("R7 stop set", int'(stop_vec[0]), 1);
    set_occ(0, 12);
    repeat (4) @(negedge clk);
    window(64);
    check("R7 stop held", int'(stop_vec[0]), 1);
    check("R7 held stop messages", scnt[0], 64);
    set_occ(0, 8);
    repeat (4) @(negedge clk);
    check("R7 held at low", int'(stop_vec[0]), 1);
    set_occ(0, 7);
    repeat (4) @(negedge clk);
    check("R7 released", int'(stop_vec[0]), 0);
    repeat (8) @(negedge clk);
    window(64);
    check("R3 silent after release", cnt[0], 0);

    // R8 mixed: stopped queue must not starve slow queue
    clear_all();
    set_occ(0, 30);
    set_occ(3, 10);
    repeat (16) @(negedge clk);
    window(64);
    check("R8 slow queue served", cnt[3], 8);
    check("R8 stopped queue rest", cnt[0], 56);
    check("R8 slow not stop", scnt[3], 0);

    // R8 all stopped: fair rotation
    clear_all();
    for (int q = 0; q < NQ; q++) set_occ(q, 28);
    repeat (16) @(negedge clk);
    rot_chk = 1;
    window(64);
    rot_chk = 0;
    for (int q = 0; q < NQ; q++) check("R8 equal share", cnt[q], 16);

    done = 1;
    report();
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end
endmodule